// File: doc/BRIEF.md
# Dual-Gain Digital AGC Loop

This block levels a complex I/Q sample stream. For each accepted sample it forms a logarithmic estimate of the sample's magnitude and adds the gain that the sample is about to receive, which gives the level the output will have. It subtracts a programmed target level from that output level to form an error, and passes the error through a second-order loop filter. The filter has one integrator and one programmable pole. The filter output is the gain itself, held in the log2 domain. The gain is converted to a linear factor: a power-of-two coarse shift times an 8-bit fine factor. The same factor scales both I and Q.

The loop has two step sizes. When the error magnitude is below a programmed threshold, the slow coefficient is used so the gain tracks gently near convergence. Otherwise the fast coefficient is used so large level changes are pulled in quickly. While the loop is disabled, the gain is held at a programmed initial value, so the block can also act as a fixed gain stage.

All levels share one log2 scale, Q.8. One integer unit is a factor of two in amplitude, about 6.02 dB. Both streaming edges use valid/ready. The block accepts a sample whenever its output register is empty or being drained. A stalled output holds its value and blocks new input. The configuration inputs are static and should change only while the pipeline is empty.

Top module: `agc_dual_gain`

## Requirements
- R1: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. A sample is accepted on a clock edge where `in_valid` and `in_ready` are both high. Accepted samples leave in acceptance order, on the second advancing edge after acceptance. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_i` and `out_q` hold their values.
- R2: After a synchronous reset (`rst_n` low at a clock edge), `out_valid` is low and `in_ready` is high. The loop gain state is loaded with `cfg_gain_init` in its upper 12 bits and zeros below. The filter state is cleared.
- R3: The level of a sample (I,Q) is computed as follows. Let p = I²+Q². Let n be the position of the highest set bit of p, with n = 0 when p is 0. Let f be the 8 bits just below that bit, with zeros shifted in as needed. The level is (n·256 + f) >> 1, in Q.8 log2 units.
- R4: The target `cfg_request` decodes to bits [7:6]·256 + bits [5:0]·4 in Q.8. The gain G is the upper 12 bits of the 20-bit gain state. The error is e = level + G − target.
- R5: The loop coefficient is `cfg_k_slow` when |e| < `cfg_thresh`, and `cfg_k_fast` otherwise, including when they are equal. `cfg_thresh` is read directly in Q.8: bits [11:8] are whole units and bits [7:0] are 1/256 units.
- R6: For each sample the filter state is updated as w ← floor(P·w/256) + k·e, where P = `cfg_pole`. The result saturates to [−2^20, 2^20−1].
- R7: The gain state is updated as g ← g − w, using the new w, and saturates to [0, 2^20−1].
- R8: A sample x is scaled using G = {c[3:0], m[7:0]}. The output is y = floor((x·(256+m)·2^c + 128)/256), saturated to ±(2^(DW−1)−1). The same G is applied to I and Q.
- R9: While `loop_en` is low, each clock edge reloads the gain state from `cfg_gain_init` and clears the filter state. Samples are then scaled by `cfg_gain_init`.
- R10: Each sample is scaled with the gain as it stood before that sample's own error updates the loop.
- R11: Cycles without a sample in flight leave the loop state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| loop_en | input | 1 | Loop enable; low holds the gain at the initial value |
| cfg_request | input | 8 | Target level, 2-bit exponent and 6-bit mantissa |
| cfg_thresh | input | 12 | Error threshold for choosing the step size, Q.8 |
| cfg_k_slow | input | 8 | Slow coefficient, n/256 |
| cfg_k_fast | input | 8 | Fast coefficient, n/256 |
| cfg_pole | input | 8 | Filter pole, n/256 |
| cfg_gain_init | input | 12 | Initial gain, 4-bit shift and 8-bit fine value |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_i | input | DW | Input in-phase sample, signed |
| in_q | input | DW | Input quadrature sample, signed |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_i | output | DW | Scaled in-phase sample |
| out_q | output | DW | Scaled quadrature sample |

## Verification
The assertions check the following on every cycle:
- Output holding under a stall, and samples moving through both pipeline stages.
- Outputs never reaching the most negative code.
- The gain reloading from `cfg_gain_init` while the loop is off, and the gain staying frozen on cycles without a sample.

The bench's scenarios are needed for the arithmetic: the log level estimate, the target decode, the choice between the slow and fast coefficient, the filter recursion with its saturations, and the rounding of the coarse and fine scaling. These are compared sample by sample against a bench-side model of the requirements, under bubbles and back-pressure, and at the gain floor.

// File: rtl/agc_pkg.sv
package agc_pkg;
  // log2 scale: FRAC fractional bits, one unit = factor 2 in amplitude
  localparam int FRAC   = 8;
  // applied gain word: 4-bit coarse shift + 8-bit fine value
  localparam int GAIN_W = 12;
  localparam int SHIFT_W = GAIN_W - FRAC;
  // gain state keeps FRAC extra fraction bits below the applied word
  localparam int GST_W  = GAIN_W + FRAC;
  // filter state: signed, two bits of headroom over the gain state
  localparam int FILT_W = GST_W + 2;
  localparam int COEF_W = 8;
  localparam int REQ_W  = 8;
endpackage

// File: rtl/agc_level_est.sv
module agc_level_est #(
  parameter int DW = 16,
  localparam int PW = 2 * DW + 1,
  localparam int POS_W = $clog2(PW),
  localparam int LV_W = POS_W + agc_pkg::FRAC
) (
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] x_q,
  output logic [LV_W-1:0]      level
);
  import agc_pkg::*;

  logic signed [2*DW-1:0] sq_i, sq_q;
  logic [PW-1:0]    pwr;
  logic [POS_W-1:0] top_bit;
  logic [PW-1:0]    norm;
  logic [LV_W-1:0]  log_pow;

  always_comb begin
    sq_i = x_i * x_i;
    sq_q = x_q * x_q;
    pwr  = {1'b0, sq_i} + {1'b0, sq_q};
    // highest set bit of the power
    top_bit = '0;
    for (int b = 0; b < PW; b++) begin
      if (pwr[b]) top_bit = POS_W'(b);
    end
    // move the leading one to the MSB; the bits below it are the fraction
    norm    = pwr << (POS_W'(PW - 1) - top_bit);
    log_pow = {top_bit, norm[PW-2 -: FRAC]};
    // power to amplitude: halve the log
    level   = log_pow >> 1;
  end
endmodule

// File: rtl/agc_loop_filter.sv
module agc_loop_filter #(
  parameter int LV_W = 14
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          loop_en,
  input  logic                          step,
  input  logic [LV_W-1:0]               level,
  input  logic [agc_pkg::REQ_W-1:0]     request,
  input  logic [agc_pkg::GAIN_W-1:0]    thresh,
  input  logic [agc_pkg::COEF_W-1:0]    k_slow,
  input  logic [agc_pkg::COEF_W-1:0]    k_fast,
  input  logic [agc_pkg::COEF_W-1:0]    pole,
  input  logic [agc_pkg::GAIN_W-1:0]    gain_init,
  output logic [agc_pkg::GAIN_W-1:0]    gain_q8
);
  import agc_pkg::*;

  localparam int EW = ((LV_W > GAIN_W) ? LV_W : GAIN_W) + 2;
  localparam int XW = ((FILT_W > EW) ? FILT_W : EW) + COEF_W + 3;
  localparam logic signed [XW-1:0] ST_HI = (XW'(1) <<< GST_W) - XW'(1);
  localparam logic signed [XW-1:0] ST_LO = -(XW'(1) <<< GST_W);

  logic [GST_W-1:0]         gain_st;
  logic signed [FILT_W-1:0] w_st;

  logic signed [EW-1:0]     err, err_abs, req_q8;
  logic [COEF_W-1:0]        k_sel;
  logic signed [XW-1:0]     pw_term, ke_term, w_sum, g_sum;
  logic signed [FILT_W-1:0] w_nxt;
  logic [GST_W-1:0]         g_nxt;

  assign gain_q8 = gain_st[GST_W-1 -: GAIN_W];

  always_comb begin
    // target: exponent in whole units, mantissa in 4/256 steps
    req_q8  = EW'($signed({1'b0, request[REQ_W-1 -: 2], request[REQ_W-3:0], 2'b00}));
    err     = EW'($signed({1'b0, level})) + EW'($signed({1'b0, gain_q8})) - req_q8;
    err_abs = err[EW-1] ? -err : err;
    k_sel   = ($unsigned(err_abs) < EW'(thresh)) ? k_slow : k_fast;

    pw_term = (XW'($signed({1'b0, pole})) * XW'(w_st)) >>> FRAC;
    ke_term = XW'($signed({1'b0, k_sel})) * XW'(err);
    w_sum   = pw_term + ke_term;
    if (w_sum > ST_HI)      w_nxt = FILT_W'(ST_HI);
    else if (w_sum < ST_LO) w_nxt = FILT_W'(ST_LO);
    else                    w_nxt = FILT_W'(w_sum);

    g_sum = XW'($signed({1'b0, gain_st})) - XW'(w_nxt);
    if (g_sum > ST_HI)      g_nxt = GST_W'(ST_HI);
    else if (g_sum < 0)     g_nxt = '0;
    else                    g_nxt = GST_W'(g_sum);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !loop_en) begin
      gain_st <= {gain_init, {FRAC{1'b0}}};
      w_st    <= '0;
    end else if (step) begin
      gain_st <= g_nxt;
      w_st    <= w_nxt;
    end
  end
endmodule

// File: rtl/agc_gain_apply.sv
module agc_gain_apply #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0]              x,
  input  logic [agc_pkg::GAIN_W-1:0]        gain,
  output logic signed [DW-1:0]              y
);
  import agc_pkg::*;

  localparam int SW = DW + FRAC + 2 + (1 << SHIFT_W);
  localparam logic signed [SW-1:0] Y_HI = (SW'(1) <<< (DW - 1)) - SW'(1);
  localparam logic signed [SW-1:0] Y_LO = -Y_HI;

  logic signed [SW-1:0] prod, shifted, rounded;

  always_comb begin
    // fine factor (256 + m)/256, then coarse 2^c, then round half up
    prod    = SW'(x) * SW'($signed({2'b01, gain[FRAC-1:0]}));
    shifted = prod <<< gain[GAIN_W-1 -: SHIFT_W];
    rounded = (shifted + (SW'(1) <<< (FRAC - 1))) >>> FRAC;
    if (rounded > Y_HI)      y = DW'(Y_HI);
    else if (rounded < Y_LO) y = DW'(Y_LO);
    else                     y = DW'(rounded);
  end
endmodule

// File: rtl/agc_dual_gain.sv
module agc_dual_gain #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 loop_en,
  input  logic [7:0]           cfg_request,
  input  logic [11:0]          cfg_thresh,
  input  logic [7:0]           cfg_k_slow,
  input  logic [7:0]           cfg_k_fast,
  input  logic [7:0]           cfg_pole,
  input  logic [11:0]          cfg_gain_init,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  import agc_pkg::*;

  localparam int LV_W  = $clog2(2 * DW + 1) + FRAC;
  localparam int LANES = 2;

  logic                 advance, step;
  logic                 s1_valid;
  logic signed [DW-1:0] s1_i, s1_q;
  logic [LV_W-1:0]      lvl_now, s1_level;
  logic [GAIN_W-1:0]    gain_q8;
  logic signed [DW-1:0] lane_in  [LANES];
  logic signed [DW-1:0] lane_out [LANES];

  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;
  assign step     = s1_valid && advance;

  agc_level_est #(.DW(DW)) u_level (
    .x_i   (in_i),
    .x_q   (in_q),
    .level (lvl_now)
  );

  agc_loop_filter #(.LV_W(LV_W)) u_loop (
    .clk       (clk),
    .rst_n     (rst_n),
    .loop_en   (loop_en),
    .step      (step),
    .level     (s1_level),
    .request   (cfg_request),
    .thresh    (cfg_thresh),
    .k_slow    (cfg_k_slow),
    .k_fast    (cfg_k_fast),
    .pole      (cfg_pole),
    .gain_init (cfg_gain_init),
    .gain_q8   (gain_q8)
  );

  assign lane_in[0] = s1_i;
  assign lane_in[1] = s1_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    agc_gain_apply #(.DW(DW)) u_apply (
      .x    (lane_in[g]),
      .gain (gain_q8),
      .y    (lane_out[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_i      <= '0;
      s1_q      <= '0;
      s1_level  <= '0;
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else if (advance) begin
      s1_valid  <= in_valid;
      s1_i      <= in_i;
      s1_q      <= in_q;
      s1_level  <= lvl_now;
      out_valid <= s1_valid;
      out_i     <= lane_out[0];
      out_q     <= lane_out[1];
    end
  end
endmodule

// File: rtl/agc_dual_gain_chk.sv
module agc_dual_gain_chk #(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [DW-1:0] out_i,
  input logic signed [DW-1:0] out_q,
  input logic                 loop_en,
  input logic [11:0]          cfg_gain_init,
  input logic [11:0]          gain_q8,
  input logic                 s1_valid,
  input logic                 step
);
  localparam logic signed [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

  // R1: a stalled output keeps its value
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_i) && $stable(out_q));

  // R1: an accepted sample occupies the first stage on the next cycle
  a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> s1_valid);

  // R1: a first-stage sample that advances becomes the output
  a_r1_drain: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && in_ready |=> out_valid);

  // R8: saturation is symmetric, the most negative code never appears
  a_r8_symmetric: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_i != MOST_NEG) && (out_q != MOST_NEG));

  // R9: a disabled loop reloads the initial gain
  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |=> gain_q8 == $past(cfg_gain_init));

  // R11: no sample in flight, no change to the gain
  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en && !step |=> $stable(gain_q8));
endmodule

bind agc_dual_gain agc_dual_gain_chk #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_i         (out_i),
  .out_q         (out_q),
  .loop_en       (loop_en),
  .cfg_gain_init (cfg_gain_init),
  .gain_q8       (gain_q8),
  .s1_valid      (s1_valid),
  .step          (step)
);

// File: tb/agc_dual_gain_test.sv
module agc_dual_gain_test;
  localparam int DW = 16;
  localparam longint YMAX = (64'sd1 <<< (DW - 1)) - 1;
  localparam longint STMAX = (64'sd1 <<< 20) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loop_en = 1'b1;
  logic [7:0] cfg_request = 8'h80;
  logic [11:0] cfg_thresh = 12'h100;
  logic [7:0] cfg_k_slow = 8'd16, cfg_k_fast = 8'd64, cfg_pole = 8'd128;
  logic [11:0] cfg_gain_init = 12'h100;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic signed [DW-1:0] in_i = '0, in_q = '0;
  logic in_ready, out_valid;
  logic signed [DW-1:0] out_i, out_q;

  int errs = 0, checks = 0;
  longint m_g, m_w;
  bit m_en;
  longint q_i[$], q_q[$];
  string cur_req = "R1";
  bit held = 1'b0;
  logic signed [DW-1:0] held_i, held_q;
  logic [15:0] lfsr = 16'hACE1;
  longint last_i;

  always #10 clk = ~clk;

  agc_dual_gain #(.DW(DW)) uut (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // model from the requirements
  function automatic longint f_level(longint i, longint q);
    longint p = i * i + q * q;
    longint n = 0, f;
    for (int b = 0; b < 40; b++) if ((p >> b) & 1) n = b;
    if (n >= 8) f = (p >> (n - 8)) & 255;
    else        f = (p << (8 - n)) & 255;
    return (n * 256 + f) >> 1;
  endfunction

  function automatic longint f_scale(longint x, longint g8);
    longint c = g8 >> 8, m = g8 & 255, v;
    v = ((x * (256 + m)) << c);
    v = (v + 128) >>> 8;
    if (v > YMAX) v = YMAX;
    if (v < -YMAX) v = -YMAX;
    return v;
  endfunction

  task automatic m_step(input longint i, input longint q);
    longint g8 = m_g >> 8;
    longint req = longint'(cfg_request[7:6]) * 256 + longint'(cfg_request[5:0]) * 4;
    longint e = f_level(i, q) + g8 - req;
    longint ae = (e < 0) ? -e : e;
    longint k = (ae < longint'(cfg_thresh)) ? longint'(cfg_k_slow) : longint'(cfg_k_fast);
    q_i.push_back(f_scale(i, g8));
    q_q.push_back(f_scale(q, g8));
    if (m_en) begin
      m_w = ((longint'(cfg_pole) * m_w) >>> 8) + k * e;
      if (m_w > STMAX) m_w = STMAX;
      if (m_w < -STMAX - 1) m_w = -STMAX - 1;
      m_g = m_g - m_w;
      if (m_g > STMAX) m_g = STMAX;
      if (m_g < 0) m_g = 0;
    end
  endtask

  // one cycle, driven and sampled after the falling edge
  task automatic tick(input bit iv, input longint xi, input longint xq, input bit ordy, output bit acc);
    in_valid = iv; in_i = DW'(xi); in_q = DW'(xq); out_ready = ordy;
    #1;
    if (held && out_valid) begin
      check(out_i == held_i && out_q == held_q, "R1 hold", out_i, held_i);
    end
    held = 1'b0;
    if (out_valid) begin
      if (out_ready) begin
        if (q_i.size() == 0) check(1'b0, "R1 extra output", out_i, 0);
        else begin
          longint ei = q_i.pop_front(), eq = q_q.pop_front();
          check(longint'(out_i) == ei, cur_req, out_i, ei);
          check(longint'(out_q) == eq, cur_req, out_q, eq);
          last_i = out_i;
        end
      end else begin
        held = 1'b1; held_i = out_i; held_q = out_q;
      end
    end
    acc = in_valid && in_ready;
    if (acc) m_step(xi, xq);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic send(input longint xi, input longint xq, input bit bp);
    bit acc = 1'b0;
    while (!acc) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick(1'b1, xi, xq, bp ? lfsr[0] : 1'b1, acc);
    end
  endtask

  task automatic drain();
    bit acc;
    for (int n = 0; n < 20 && (q_i.size() != 0 || out_valid); n++) tick(1'b0, 0, 0, 1'b1, acc);
    check(q_i.size() == 0, "R1 drain", q_i.size(), 0);
  endtask

  task automatic configure(input bit en, input logic [7:0] req, input logic [11:0] thr,
                           input logic [7:0] ks, input logic [7:0] kf, input logic [7:0] pl,
                           input logic [11:0] gi);
    bit acc;
    drain();
    loop_en = en; cfg_request = req; cfg_thresh = thr;
    cfg_k_slow = ks; cfg_k_fast = kf; cfg_pole = pl; cfg_gain_init = gi;
    m_en = en;
    if (!en) begin m_g = longint'(gi) << 8; m_w = 0; end
    tick(1'b0, 0, 0, 1'b1, acc);
  endtask

  task automatic t_reset();
    bit acc;
    repeat (3) @(negedge clk);
    m_en = 1'b1; m_g = longint'(cfg_gain_init) << 8; m_w = 0;
    #1;
    check(out_valid == 1'b0, "R2 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R2 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R2 in_ready after reset", in_ready, 1);
    // first sample must see the initial gain x2
    cur_req = "R2 initial gain";
    send(1000, -500, 1'b0);
    tick(1'b0, 0, 0, 1'b1, acc);
    tick(1'b0, 0, 0, 1'b1, acc);
    check(last_i == 2000, "R2 first output", last_i, 2000);
    drain();
  endtask

  task automatic t_fixed();
    logic [11:0] gains [5] = '{12'h000, 12'h080, 12'h1FF, 12'h3C0, 12'hF00};
    cur_req = "R8/R9 fixed gain";
    for (int gidx = 0; gidx < 5; gidx++) begin
      configure(1'b0, 8'h80, 12'h100, 8'd50, 8'd200, 8'd100, gains[gidx]);
      send(1234, -4321, 1'b0);
      send(-32768, 32767, 1'b0);
      send(-1, 1, 1'b0);
      send(0, 77, 1'b0);
    end
    drain();
    // unity gain passes the sample through, lanes agree
    configure(1'b0, 8'h80, 12'h100, 8'd50, 8'd200, 8'd100, 12'h000);
    send(-3210, -3210, 1'b0);
    drain();
    check(last_i == -3210, "R8 unity pass", last_i, -3210);
  endtask

  task automatic t_track();
    configure(1'b0, 8'h00, 12'h0A0, 8'd20, 8'd90, 8'd128, 12'h200);
    configure(1'b1, 8'hA5, 12'h0A0, 8'd20, 8'd90, 8'd128, 12'h200);
    cur_req = "R3/R4/R6/R7/R10 tracking";
    for (int n = 0; n < 80; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send($signed(lfsr) >>> (n % 7), $signed({lfsr[7:0], lfsr[15:8]}) >>> 3, 1'b0);
    end
    drain();
  endtask

  task automatic t_switch();
    longint first;
    // R5: threshold above every error, slow coefficient zero: gain frozen
    configure(1'b0, 8'h40, 12'hFFF, 8'd0, 8'd255, 8'd0, 12'h180);
    configure(1'b1, 8'h40, 12'hFFF, 8'd0, 8'd255, 8'd0, 12'h180);
    cur_req = "R5 slow coefficient";
    send(500, 0, 1'b0);
    drain();
    first = last_i;
    for (int n = 0; n < 10; n++) send(500, 0, 1'b0);
    drain();
    check(last_i == first, "R5 frozen with slow zero", last_i, first);
    // threshold zero: fast coefficient always used, gain moves
    configure(1'b1, 8'h40, 12'h000, 8'd0, 8'd40, 8'd0, 12'h180);
    cur_req = "R5 fast coefficient";
    for (int n = 0; n < 10; n++) send(500, 0, 1'b0);
    drain();
    check(last_i != first, "R5 gain moved with fast", last_i, first);
    // exact threshold boundary: |e| == T uses fast
    cur_req = "R5 boundary";
    for (int n = 0; n < 6; n++) send(700 + 9 * n, -20, 1'b0);
    drain();
  endtask

  task automatic t_stream();
    bit acc;
    configure(1'b0, 8'h90, 12'h080, 8'd30, 8'd120, 8'd200, 12'h300);
    configure(1'b1, 8'h90, 12'h080, 8'd30, 8'd120, 8'd200, 12'h300);
    cur_req = "R1/R11 backpressure";
    for (int n = 0; n < 120; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3]) send($signed(lfsr) >>> 2, -($signed(lfsr) >>> 4), 1'b1);
      else tick(1'b0, 0, 0, lfsr[1], acc);
    end
    drain();
    // R11: idle cycles between two identical samples
    cur_req = "R11 idle gap";
    send(3000, 4000, 1'b0);
    repeat (15) tick(1'b0, 0, 0, 1'b1, acc);
    send(3000, 4000, 1'b0);
    drain();
  endtask

  task automatic t_floor();
    configure(1'b0, 8'h01, 12'h000, 8'd0, 8'd255, 8'd0, 12'h400);
    configure(1'b1, 8'h01, 12'h000, 8'd0, 8'd255, 8'd0, 12'h400);
    cur_req = "R7 gain floor";
    for (int n = 0; n < 8; n++) send(20000, -15000, 1'b0);
    drain();
    check(last_i == 20000, "R7 floor gives unity", last_i, 20000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_fixed();
    t_track();
    t_switch();
    t_stream();
    t_floor();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule